// File: doc/BRIEF.md
# Streaming Table-Driven Coefficient Quantizer

The block turns a stream of signed transform coefficients into quantized levels. It takes one 12-bit coefficient per clock, qualified by a valid strobe. It divides each coefficient by a step size read from an internal constant table and rounds the quotient to the nearest integer. The result leaves on a matching valid strobe a fixed four clocks later. There is no back-pressure. The divider accepts a new sample on every clock, and idle cycles on the input show up as idle cycles on the output.

Coefficients arrive in groups of 64 samples. An internal position counter advances on every valid sample and selects the table entry for that sample. A 2-bit component selector, sampled together with each coefficient, picks one of two tables. One table serves the two brightness components and the other serves the two colour-difference components. When the 64th valid sample has been taken, the counter returns to zero, so the next group starts at the first table entry. No external block marker is needed.

Top module: `coef_quantizer`

## Requirements
- R1: When a sample is taken, a `compSel` value of 0 or 1 selects table 0 and a value of 2 or 3 selects table 1.
- R2: The step size for position i (0..63) is taken from one of two formulas. Table 0 gives i for i < 4 and 4 + ((37*i) mod 252) otherwise. Table 1 gives 255 - 4*i. All values lie in 0..255.
- R3: The position counter is 0 after reset. It advances by one only on cycles with `inValid` high, and it returns to 0 after position 63, so sample 65 of a continuous stream uses position 0 again.
- R4: The output is the quotient coefficient/step rounded to the nearest integer, with exact halves rounded away from zero. For example, 7/2 gives 4 and -7/2 gives -4. The full input range -2048..2047 is supported, and the result is a 12-bit two's-complement value.
- R5: A step size of 0 gives an output of exactly 0, whatever the coefficient.
- R6: `outValid` is high exactly four clocks after each cycle in which `inValid` was high, and low otherwise. Results come out in input order, and input gaps appear unchanged on the output.
- R7: During and right after reset, `outValid` and `outQuot` are 0.
- R8: Back-to-back valid samples on consecutive clocks each produce a result, one per clock, with no stall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| compSel | input | 2 | Component of the current sample; values 2 and 3 select table 1 |
| inValid | input | 1 | The coefficient on `inCoef` is taken on this clock |
| inCoef | input | 12 | Signed coefficient |
| outValid | output | 1 | `outQuot` carries a result |
| outQuot | output | 12 | Signed rounded quotient |

## Verification
The hardest case to reach from the ports is a sample whose coefficient lands exactly halfway between two quotients at a known table position. The position is never visible; it is implied only by how many valid samples have gone by. The stimulus therefore keeps its own position count, reads the step size for that position from the table formula, and builds an exact-half coefficient of either sign whenever the step is even. It also crosses the 64-sample wrap inside a continuous run, inserts idle cycles mid-group, and drives the end-of-range coefficients against steps of 0, 1 and 2.

// File: rtl/coefq_pkg.sv
package coefq_pkg;

  localparam int IDX_W_DEF = 6;
  localparam int DIV_W_DEF = 8;

  // One strobe bundle per clock from control to datapath
  typedef struct packed {
    logic                 take;
    logic [IDX_W_DEF:0]   romAddr;   // {table, position}
  } ctrl_strobe_t;

  // Step-size table, computed rather than listed
  function automatic logic [DIV_W_DEF-1:0] stepSize(input logic [IDX_W_DEF:0] addr);
    int pos;
    int val;
    pos = int'(addr[IDX_W_DEF-1:0]);
    if (addr[IDX_W_DEF]) begin
      val = 255 - 4 * pos;
    end else if (pos < 4) begin
      val = pos;
    end else begin
      val = 4 + ((37 * pos) % 252);
    end
    return DIV_W_DEF'(val);
  endfunction

endpackage

// File: rtl/coefq_ctrl.sv
module coefq_ctrl
  import coefq_pkg::*;
#(
  parameter int IDX_W = IDX_W_DEF,
  parameter int LAT   = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inValid,
  input  logic [1:0]   compSel,
  output ctrl_strobe_t strobe,
  output logic         outValid
);

  localparam logic [IDX_W-1:0] LAST_POS = {IDX_W{1'b1}};

  logic [IDX_W-1:0] posCnt;
  logic [LAT-1:0]   validLine;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      posCnt <= '0;
    end else if (inValid) begin
      posCnt <= (posCnt == LAST_POS) ? '0 : posCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) validLine <= '0;
    else        validLine <= {validLine[LAT-2:0], inValid};
  end

  always_comb begin
    strobe.take    = inValid;
    strobe.romAddr = {compSel[1], posCnt};
  end

  assign outValid = validLine[LAT-1];

  assert_pos_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && posCnt == LAST_POS) |=> (posCnt == '0));

  assert_pos_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> $stable(posCnt));

  assert_valid_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |-> ##4 outValid);

  assert_gap_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |-> ##4 !outValid);

endmodule

// File: rtl/coefq_datapath.sv
module coefq_datapath
  import coefq_pkg::*;
#(
  parameter int COEF_W = 12,
  parameter int DIV_W  = DIV_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrl_strobe_t      strobe,
  input  logic [COEF_W-1:0] inCoef,
  output logic [COEF_W-1:0] outQuot
);

  localparam int MAG_W = COEF_W + 1;   // room for 2*|a| + d
  localparam int DEN_W = DIV_W + 1;

  // stage 1: operand capture with table lookup
  logic [COEF_W-1:0] s1Coef;
  logic [DIV_W-1:0]  s1Div;
  // stage 2: magnitude, rounding bias, sign
  logic [MAG_W-1:0]  s2Num;
  logic [DEN_W-1:0]  s2Den;
  logic              s2Sign, s2Zero;
  // stage 3: unsigned division
  logic [MAG_W-1:0]  s3Mag;
  logic              s3Sign, s3Zero;

  logic signed [MAG_W-1:0] extCoef;
  logic [MAG_W-1:0]        absCoef;
  logic [MAG_W-1:0]        negMag;

  always_comb begin
    extCoef = MAG_W'($signed(s1Coef));
    absCoef = extCoef[MAG_W-1] ? MAG_W'(-extCoef) : MAG_W'(extCoef);
    negMag  = MAG_W'(0) - s3Mag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1Coef <= '0;
      s1Div  <= '0;
      s2Num  <= '0;
      s2Den  <= '0;
      s2Sign <= 1'b0;
      s2Zero <= 1'b0;
      s3Mag  <= '0;
      s3Sign <= 1'b0;
      s3Zero <= 1'b0;
      outQuot <= '0;
    end else begin
      s1Coef <= strobe.take ? inCoef : '0;
      s1Div  <= stepSize(strobe.romAddr);

      s2Num  <= {absCoef[MAG_W-2:0], 1'b0} + MAG_W'(s1Div);
      s2Den  <= {s1Div, 1'b0};
      s2Sign <= s1Coef[COEF_W-1];
      s2Zero <= (s1Div == '0);

      s3Mag  <= s2Zero ? '0 : s2Num / MAG_W'(s2Den);
      s3Sign <= s2Sign;
      s3Zero <= s2Zero;

      outQuot <= s3Sign ? negMag[COEF_W-1:0] : s3Mag[COEF_W-1:0];
    end
  end

  assert_zero_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    s3Zero |=> (outQuot == '0));

  assert_sign_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (s3Mag != '0) |=> (outQuot[COEF_W-1] == $past(s3Sign)));

endmodule

// File: rtl/coef_quantizer.sv
module coef_quantizer
  import coefq_pkg::*;
#(
  parameter int COEF_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        compSel,
  input  logic              inValid,
  input  logic [COEF_W-1:0] inCoef,
  output logic              outValid,
  output logic [COEF_W-1:0] outQuot
);

  ctrl_strobe_t strobe;

  coefq_ctrl #(.IDX_W(IDX_W_DEF), .LAT(4)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (inValid),
    .compSel  (compSel),
    .strobe   (strobe),
    .outValid (outValid)
  );

  coefq_datapath #(.COEF_W(COEF_W), .DIV_W(DIV_W_DEF)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .inCoef  (inCoef),
    .outQuot (outQuot)
  );

  assert_reset_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !outValid);

endmodule

// File: tb/coef_quantizer_tb.sv
module coef_quantizer_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  compSel = '0;
  logic        inValid = 1'b0;
  logic [11:0] inCoef = '0;
  logic        outValid;
  logic [11:0] outQuot;

  always #4 clk = ~clk;   // 125 MHz

  coef_quantizer u_dut (
    .clk(clk), .rst_n(rst_n), .compSel(compSel), .inValid(inValid),
    .inCoef(inCoef), .outValid(outValid), .outQuot(outQuot)
  );

  typedef struct {
    int    expVal;
    int    dueCyc;
    string tag;
  } item_t;

  item_t sbq[$];
  int cyc = 0;
  int checks = 0;
  int fails = 0;
  int benchPos = 0;
  int sentTotal = 0;
  int lcg = 12345;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int refStep(int tbl, int pos);
    if (tbl == 1) return 255 - 4 * pos;
    if (pos < 4) return pos;
    return 4 + ((37 * pos) % 252);
  endfunction

  function automatic int refQuant(int a, int d);
    int m;
    if (d == 0) return 0;
    m = (a < 0) ? -a : a;
    m = (2 * m + d) / (2 * d);
    return (a < 0) ? -m : m;
  endfunction

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #2;
      inValid = 1'b0;
      inCoef  = '0;
    end
  endtask

  task automatic send(int a, int comp);
    int tbl, d, m;
    item_t it;
    @(posedge clk); #2;
    tbl = (comp >= 2) ? 1 : 0;
    d = refStep(tbl, benchPos);
    m = (a < 0) ? -a : a;
    it.expVal = refQuant(a, d);
    it.dueCyc = cyc + 4;
    if (d == 0) it.tag = "R5";
    else if ((2 * (m % d)) == d) it.tag = "R4";
    else if (tbl == 1) it.tag = "R1";
    else if (sentTotal >= 64) it.tag = "R3";
    else it.tag = "R2/R8";
    sbq.push_back(it);
    compSel = 2'(comp);
    inValid = 1'b1;
    inCoef  = 12'(a);
    benchPos = (benchPos == 63) ? 0 : benchPos + 1;
    sentTotal++;
  endtask

  function automatic int pickCoef(int comp);
    int d;
    d = refStep((comp >= 2) ? 1 : 0, benchPos);
    lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
    case (benchPos % 5)
      0: return (d % 2 == 0 && d != 0) ? (3 * d + d / 2) : 2047;
      1: return (d % 2 == 0 && d != 0) ? -(2 * d + d / 2) : -2048;
      2: return -2048;
      3: return 2047;
      default: return ((lcg >> 4) % 4096) - 2048;
    endcase
  endfunction

  // monitor: compare in due cycle, flag unexpected valids
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (sbq.size() > 0 && sbq[0].dueCyc == cyc) begin
        item_t it;
        it = sbq.pop_front();
        checks++;
        if (!outValid) begin
          fails++;
          $display("FAIL R6 cyc %0d: outValid=0, expected 1", cyc);
        end else if ($signed(outQuot) != it.expVal) begin
          fails++;
          $display("FAIL %s cyc %0d: outQuot=%0d, expected %0d", it.tag, cyc,
                   $signed(outQuot), it.expVal);
        end
      end else if (outValid) begin
        checks++;
        fails++;
        $display("FAIL R6 cyc %0d: outValid=1, expected 0", cyc);
      end
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (outValid !== 1'b0 || outQuot !== 12'd0) begin
      fails++;
      $display("FAIL R7: outValid=%b outQuot=%0d, expected 0 0", outValid, outQuot);
    end
    @(posedge clk); #2;
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (outValid !== 1'b0) begin
      fails++;
      $display("FAIL R7: outValid=%b after release, expected 0", outValid);
    end

    // group on table 0, continuous (R2, R4, R5, R8)
    for (int i = 0; i < 64; i++) send(pickCoef(0), (i % 2));
    // table 1 group with gaps (R1, R6)
    for (int i = 0; i < 64; i++) begin
      send(pickCoef(3), (i % 3 == 0) ? 2 : 3);
      if (i % 7 == 3) idle(1 + i % 3);
    end
    idle(2);
    // continuous run crossing the wrap mid-run (R3)
    for (int i = 0; i < 90; i++) send(pickCoef(1), 1);
    // finish the partial group on table 1, then exact ties by hand (R4)
    for (int i = 0; i < 38; i++) send(pickCoef(2), 2);
    send(0, 0);      // pos 0, step 0 (R5)
    send(2047, 0);   // pos 1, step 1
    send(-3, 0);     // pos 2, step 2: -1.5 -> -2 (R4)
    send(3, 0);      // pos 3, step 3: exact 1
    idle(8);
    done = 1'b1;
    checks++;
    if (sbq.size() != 0) begin
      fails++;
      $display("FAIL R6: %0d results missing, expected 0", sbq.size());
    end
    summary();
  end

endmodule